// File: doc/BRIEF.md
# Windowed Voltage Monitor Averager

This block accumulates signed conversion results for three voltage sense channels: a local point, an auxiliary point and a differential remote point. The accumulation window is a fixed number of clock ticks, `WIN_TICKS`, and the default corresponds to 10 ms at 100 MHz. Every tagged sample that arrives inside a window is added to its channel's running sum, and the number of samples is counted. On the last tick of the window, each channel's average is written into its value register and the sums are cleared. A reader that polls at least once per window therefore always sees a complete window average and never a partial one.

A small register read port returns the three values at fixed consecutive addresses. A registered selector picks the channel that feeds the regulation loop, based on the state of the output switch. While the switch is open, the local point is forwarded. While it is closed, the differential remote point is forwarded.

Top module: `vmon_avg`

## Requirements
- R1: A window lasts exactly `WIN_TICKS` clock edges. The first window starts at the first rising edge after reset is released. Results are published on the last edge of each window.
- R2: Channel code 0 is local, 1 is auxiliary and 2 is remote. Every valid sample with one of these codes is accumulated into its channel, and a sample on the final edge of a window counts toward that window. A valid sample with code 3 has no effect.
- R3: The published value is the window sum arithmetically shifted right by floor(log2(count)), then saturated to the signed `DW`-bit range. When the count is a power of two, this is the exact floor average. A window with no samples publishes 0.
- R4: Between publishes, each value register holds its previous result.
- R5: A read with `rd_en_i` high returns data one cycle later. Address `BASE_ADDR` (0x15) returns the local value, 0x16 the auxiliary value and 0x17 the remote value, with `rd_hit_o` high. Any other address returns 0 with `rd_hit_o` low.
- R6: A read issued on the publish edge returns the complete previous value.
- R7: `sel_chan_o` is registered. It takes code 0 when `sw_on_i` is low and code 2 when `sw_on_i` is high, and it follows the input on the next edge.
- R8: A valid sample whose code equals the selector value held before an edge appears on `loop_data_o`, with `loop_valid_o` high, after that edge. Samples on any other channel leave `loop_valid_o` low.
- R9: Reset clears the sums, counts, value registers, read output and window timer, and sets the selector to local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 2 | Sample channel code |
| smp_data_i | input | DW | Signed sample value |
| sw_on_i | input | 1 | Output switch state |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DW | Read data, one cycle after the strobe |
| rd_hit_o | output | 1 | Read address was mapped |
| sel_chan_o | output | 2 | Loop sense channel code |
| loop_valid_o | output | 1 | Forwarded loop sample strobe |
| loop_data_o | output | DW | Forwarded loop sample |

## Verification
The assertions check several behaviours on every cycle:
- the spacing between window ends;
- that the value registers do not change off the window boundary;
- that the selector follows the switch one edge later;
- that a local-address read returns the value held before the edge, including on the publish edge;
- the reset state.

The arithmetic itself can only be shown by the bench's windows of chosen traffic. These cover:
- full and sparse windows;
- non-power-of-two counts that round and saturate;
- ignored channel code 3 and samples on the final window edge;
- empty windows and a reset in mid-window.

The bench also compares the forwarded loop samples against the switch history.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic [1:0] {
    CH_LOCAL  = 2'd0,
    CH_AUX    = 2'd1,
    CH_REMOTE = 2'd2,
    CH_NONE   = 2'd3
  } vmon_chan_e;
endpackage

// File: rtl/vmon_window_timer.sv
module vmon_window_timer #(
  parameter int unsigned WIN_TICKS = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int unsigned CW = $clog2(WIN_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] tick_q;

  assign win_end_o = (tick_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tick_q <= '0;
    else if (win_end_o) tick_q <= '0;
    else                tick_q <= tick_q + CW'(1);
  end
endmodule

// File: rtl/vmon_chan_acc.sv
module vmon_chan_acc #(
  parameter int unsigned DW        = 12,
  parameter int unsigned WIN_TICKS = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [DW-1:0] data_i,
  input  logic          win_end_i,
  output logic [DW-1:0] avg_o
);
  localparam int unsigned CW = $clog2(WIN_TICKS + 1);
  localparam int unsigned AW = DW + CW;
  localparam int unsigned SW = $clog2(CW) + 1;
  localparam logic signed [AW-1:0] MAXV = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [AW-1:0] sum_q, sum_nx, data_ext, scaled;
  logic [CW-1:0]        cnt_q, cnt_nx;
  logic [SW-1:0]        shamt;
  logic [DW-1:0]        avg_q, avg_nx;

  // floor(log2(count)); zero count gives zero shift on a zero sum
  function automatic logic [SW-1:0] flog2(input logic [CW-1:0] c);
    logic [SW-1:0] r;
    r = '0;
    for (int i = 0; i < int'(CW); i++) begin
      if (c[i]) r = SW'(i);
    end
    return r;
  endfunction

  assign data_ext = {{CW{data_i[DW-1]}}, data_i};
  assign sum_nx   = hit_i ? sum_q + data_ext : sum_q;
  assign cnt_nx   = cnt_q + CW'(hit_i);
  assign shamt    = flog2(cnt_nx);
  assign scaled   = sum_nx >>> shamt;

  always_comb begin
    if (scaled > MAXV)      avg_nx = MAXV[DW-1:0];
    else if (scaled < MINV) avg_nx = MINV[DW-1:0];
    else                    avg_nx = scaled[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
      avg_q <= '0;
    end else if (win_end_i) begin
      sum_q <= '0;
      cnt_q <= '0;
      avg_q <= avg_nx;
    end else begin
      sum_q <= sum_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign avg_o = avg_q;
endmodule

// File: rtl/vmon_loop_sel.sv
module vmon_loop_sel
  import vmon_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_on_i,
  input  logic          smp_valid_i,
  input  logic [1:0]    smp_chan_i,
  input  logic [DW-1:0] smp_data_i,
  output logic [1:0]    sel_chan_o,
  output logic          loop_valid_o,
  output logic [DW-1:0] loop_data_o
);
  vmon_chan_e    sel_q;
  logic          lv_q;
  logic [DW-1:0] ld_q;
  logic          match;

  assign match = smp_valid_i && (vmon_chan_e'(smp_chan_i) == sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= CH_LOCAL;
      lv_q  <= 1'b0;
      ld_q  <= '0;
    end else begin
      sel_q <= sw_on_i ? CH_REMOTE : CH_LOCAL;
      lv_q  <= match;
      if (match) ld_q <= smp_data_i;
    end
  end

  assign sel_chan_o   = sel_q;
  assign loop_valid_o = lv_q;
  assign loop_data_o  = ld_q;
endmodule

// File: rtl/vmon_avg.sv
module vmon_avg
  import vmon_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter int unsigned WIN_TICKS = 1000000,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 8'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [1:0]        smp_chan_i,
  input  logic [DW-1:0]     smp_data_i,
  input  logic              sw_on_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_hit_o,
  output logic [1:0]        sel_chan_o,
  output logic              loop_valid_o,
  output logic [DW-1:0]     loop_data_o
);
  logic                      win_end;
  logic [NUM_CH-1:0][DW-1:0] avg_w;
  logic [ADDR_W-1:0]         rd_off;
  logic                      rd_map;
  logic [DW-1:0]             rd_mux;
  logic [DW-1:0]             rd_data_q;
  logic                      rd_hit_q;

  vmon_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_o (win_end)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = smp_valid_i && (smp_chan_i == 2'(ch));
    vmon_chan_acc #(.DW(DW), .WIN_TICKS(WIN_TICKS)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit),
      .data_i    (smp_data_i),
      .win_end_i (win_end),
      .avg_o     (avg_w[ch])
    );
  end

  vmon_loop_sel #(.DW(DW)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_on_i      (sw_on_i),
    .smp_valid_i  (smp_valid_i),
    .smp_chan_i   (smp_chan_i),
    .smp_data_i   (smp_data_i),
    .sel_chan_o   (sel_chan_o),
    .loop_valid_o (loop_valid_o),
    .loop_data_o  (loop_data_o)
  );

  assign rd_off = rd_addr_i - ADDR_W'(BASE_ADDR);
  assign rd_map = (rd_addr_i >= ADDR_W'(BASE_ADDR)) && (rd_off < ADDR_W'(NUM_CH));

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < int'(NUM_CH); ch++) begin
      if (rd_map && rd_off == ADDR_W'(ch)) rd_mux = avg_w[ch];
    end
  end

  // read samples the pre-edge value, so a publish-edge read is never torn
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      rd_hit_q  <= 1'b0;
    end else if (rd_en_i) begin
      rd_data_q <= rd_mux;
      rd_hit_q  <= rd_map;
    end
  end

  assign rd_data_o = rd_data_q;
  assign rd_hit_o  = rd_hit_q;
endmodule

// File: rtl/vmon_avg_chk.sv
module vmon_avg_chk #(
  parameter int unsigned DW        = 12,
  parameter int unsigned WIN_TICKS = 1000000,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 8'h15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sw_on_i,
  input logic [1:0]           sel_chan_o,
  input logic                 rd_en_i,
  input logic [ADDR_W-1:0]    rd_addr_i,
  input logic [DW-1:0]        rd_data_o,
  input logic                 win_end_i,
  input logic [2:0][DW-1:0]   avg_i
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= 0;
    else if (win_end_i) gap_q <= 0;
    else                gap_q <= gap_q + 1;
  end

  a_r1_win_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |-> gap_q == WIN_TICKS - 1);

  a_r1_win_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < WIN_TICKS);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(avg_i));

  a_r7_sel_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_i |=> sel_chan_o == 2'd2);

  a_r7_sel_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_on_i |=> sel_chan_o == 2'd0);

  a_r6_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == ADDR_W'(BASE_ADDR)) |=> rd_data_o == $past(avg_i[0]));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset: assert (sel_chan_o == 2'd0 && rd_data_o == '0 && avg_i == '0);
    end
  end
endmodule

bind vmon_avg vmon_avg_chk #(
  .DW(DW), .WIN_TICKS(WIN_TICKS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_on_i    (sw_on_i),
  .sel_chan_o (sel_chan_o),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .win_end_i  (win_end),
  .avg_i      (avg_w)
);

// File: tb/sim_vmon_avg.sv
module sim_vmon_avg;
  localparam int CLK_P = 10;
  localparam int DW    = 12;
  localparam int WIN   = 64;
  localparam int BASE  = 'h15;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          smp_valid_i = 1'b0;
  logic [1:0]    smp_chan_i = '0;
  logic [DW-1:0] smp_data_i = '0;
  logic          sw_on_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [7:0]    rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_hit_o;
  logic [1:0]    sel_chan_o;
  logic          loop_valid_o;
  logic [DW-1:0] loop_data_o;

  always #(CLK_P / 2) clk = ~clk;

  vmon_avg #(.DW(DW), .WIN_TICKS(WIN), .ADDR_W(8), .BASE_ADDR(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_chan_i(smp_chan_i),
    .smp_data_i(smp_data_i), .sw_on_i(sw_on_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_hit_o(rd_hit_o), .sel_chan_o(sel_chan_o),
    .loop_valid_o(loop_valid_o), .loop_data_o(loop_data_o)
  );

  int          checks = 0;
  int          errors = 0;
  longint      acc [3];
  int          cnt [3];
  int          pub [3];
  bit          sel_prev = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  string       prev_lbl = "R9";

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int avg_of(longint s, int c);
    int sh = 0;
    longint r;
    if (c == 0) return 0;
    for (int i = 0; i < 31; i++) if (((c >> i) & 1) == 1) sh = i;
    r = s >>> sh;
    if (r > 2047)  r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic clear_model();
    for (int c = 0; c < 3; c++) begin
      acc[c] = 0; cnt[c] = 0; pub[c] = 0;
    end
    sel_prev = 1'b0;
  endtask

  task automatic step(bit v, int ch, int d, bit rden, int addr, bit sw, bit last, string lbl);
    bit exp_lv, mapped;
    int ev;
    smp_valid_i = v; smp_chan_i = ch[1:0]; smp_data_i = d[DW-1:0];
    rd_en_i = rden; rd_addr_i = addr[7:0]; sw_on_i = sw;
    if (v && ch < 3) begin acc[ch] += d; cnt[ch]++; end
    @(negedge clk);
    chk(sel_chan_o == (sw ? 2'd2 : 2'd0), "R7", int'(sel_chan_o), sw ? 2 : 0);
    exp_lv = v && (ch == (sel_prev ? 2 : 0));
    chk(loop_valid_o == exp_lv, "R8", int'(loop_valid_o), int'(exp_lv));
    if (exp_lv) chk($signed(loop_data_o) == d, "R8", int'($signed(loop_data_o)), d);
    sel_prev = sw;
    if (rden) begin
      mapped = (addr >= BASE) && (addr < BASE + 3);
      ev = mapped ? pub[addr - BASE] : 0;
      chk(rd_hit_o == mapped, "R5", int'(rd_hit_o), int'(mapped));
      chk($signed(rd_data_o) == ev, lbl, int'($signed(rd_data_o)), ev);
    end
    if (last) begin
      for (int c = 0; c < 3; c++) begin
        pub[c] = avg_of(acc[c], cnt[c]);
        acc[c] = 0; cnt[c] = 0;
      end
    end
  endtask

  task automatic gen(int mode, int k, output bit v, output int ch, output int d);
    v = 1'b0; ch = 0; d = 0;
    case (mode)
      1: begin v = 1'b1; ch = k % 4; d = ((k * 173 + 91) % 4096) - 2048; end
      2: begin v = 1'b1; ch = 0; d = 2047; end
      3: begin
        if (k < 32) begin v = 1'b1; ch = 2; d = -2048; end
        else if (k >= 40 && k <= 42) begin v = 1'b1; ch = 1; d = k - 50; end
        else if (k >= 50) begin v = 1'b1; ch = 3; d = 2047; end  // R2 ignored code
      end
      4: begin
        seed = seed * 32'd1103515245 + 32'd12345;
        v = seed[20];
        ch = int'(seed[9:8]);
        d = int'($signed(seed[27:16]));
      end
      5: begin v = (k == 63); ch = 1; d = 1000; end  // R2 final-edge sample only
      default: ;
    endcase
  endtask

  // one window; reads return results of the previous window
  task automatic run_window(int mode, string lbl, int len);
    bit v; int ch, d; bit rden; int addr; bit sw;
    for (int k = 0; k < len; k++) begin
      gen(mode, k, v, ch, d);
      rden = 1'b1; addr = 0;
      if (k <= 2)       addr = BASE + k;
      else if (k == 40) addr = BASE + 1;
      else if (k == 50) addr = BASE + 3;
      else if (k == 63) addr = BASE;
      else              rden = 1'b0;
      sw = (k < 32) ? mode[0] : mode[1];
      step(v, ch, d, rden, addr, sw, k == WIN - 1,
           (k == 63) ? "R6" : (k == 40 ? "R4" : (k == 50 ? "R5" : prev_lbl)));
    end
    prev_lbl = lbl;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    smp_valid_i = 1'b0; rd_en_i = 1'b0; sw_on_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_chan_o == 2'd0, "R9", int'(sel_chan_o), 0);
    chk(rd_data_o == '0, "R9", int'(rd_data_o), 0);
    chk(loop_valid_o == 1'b0, "R9", int'(loop_valid_o), 0);
    clear_model();
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    run_window(0, "R3 R1", WIN);     // empty window publishes 0
    run_window(1, "R2 R3", WIN);     // round robin, code 3 skipped, 16 each
    run_window(2, "R3", WIN);        // full window at max code
    run_window(3, "R2 R3", WIN);     // 32 at min, 3 samples odd count, code 3 ignored
    run_window(4, "R3", WIN);        // pseudo-random, odd counts, saturation
    run_window(5, "R2 R1", WIN);     // only a final-edge sample
    run_window(1, "R2", WIN);
    run_window(0, "R3", WIN);
    run_window(4, "R3", 20);         // partial window, then reset
    do_reset();
    prev_lbl = "R9";
    run_window(0, "R9", WIN);
    run_window(0, "R3", WIN);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule